// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits behind the bus capture logic of a NOR-style flash and decides what every captured write means. A write is either a one-byte command (the low eight bits of the data word) or, right after a program-setup command, the location and value to program. The sequencer tracks the device mode. It chooses which source the read path returns: array, identifier or status. It hands program and erase jobs to an external algorithm engine and keeps an eight-bit status register whose error flags stay set until software clears them.

Captured writes arrive on a valid/ready stream. A write is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` falls while a job request waits for the engine, so the bus side must hold its write until `wr_ready` returns. Job requests leave on a second valid/ready stream. The payload stays stable until `req_ready` accepts it. Suspend and resume are single-cycle pulses. The engine reports the end of a job with `eng_done` and `eng_fail`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read source is array (`rd_src` = 0), no request is pending, and status reads 0x80. Status layout: bit 7 ready (1 = no job running), bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 protection violation, bits 2..0 zero.
- R2: When idle, command FFh sets `rd_src` to 0 (array), 90h sets it to 1 (identifier) and 70h sets it to 2 (status). `id_word` returns `MFR_ID` when `rd_a0` is 0 and `DEV_ID` when it is 1.
- R3: Command 50h when idle clears status bits 5..3 and leaves the read source and every other bit unchanged.
- R4: Command 20h followed at once by D0h issues an erase request (`req_erase` = 1) whose address is the address of the D0h write. The read source becomes status and bit 7 drops to 0.
- R5: Command 40h or 10h followed by any write issues a program request (`req_erase` = 0) that carries the address and the full data word of that second write. The read source becomes status.
- R6: Code 00h, any code outside the set, a lone D0h, or anything other than D0h after 20h sets status bits 5 and 4, returns the read source to array, and issues no request.
- R7: A program or erase whose address has its top `AW-BOOT_BITS` bits all ones is refused unless `hv_unlock` or `wp_high` is high. A refused job sets status bit 3, issues no request, and switches the read source to status.
- R8: B0h during a running erase emits one `eng_suspend` pulse and sets bit 6 and bit 7. B0h while idle or while programming has no effect.
- R9: While suspended, only 70h, FFh and D0h take effect. D0h emits one `eng_resume` pulse, clears bit 6, clears bit 7 and selects status. Any other write changes nothing.
- R10: While a job runs, FFh, 90h and 70h still change the read source. `eng_done` ends the job and sets bit 7. `eng_fail` with it sets bit 4 after a program or bit 5 after an erase. `eng_done` at other times is ignored.
- R11: A pending request holds `req_valid`, `req_addr`, `req_data` and `req_erase` stable until `req_ready`, and `wr_ready` stays low meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Captured bus write present |
| wr_ready | output | 1 | Sequencer can take a write |
| wr_addr | input | AW | Address of the write |
| wr_data | input | DW | Data of the write; command in bits 7..0 |
| hv_unlock | input | 1 | Reset pin at high-voltage level |
| wp_high | input | 1 | Write-protect pin high |
| req_valid | output | 1 | Job request pending |
| req_ready | input | 1 | Engine accepts the request |
| req_erase | output | 1 | 1 erase, 0 program |
| req_addr | output | AW | Job address |
| req_data | output | DW | Program data |
| eng_suspend | output | 1 | Suspend pulse to engine |
| eng_resume | output | 1 | Resume pulse to engine |
| eng_done | input | 1 | Job finished |
| eng_fail | input | 1 | Job failed (with eng_done) |
| rd_src | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| status | output | 8 | Status register |
| rd_a0 | input | 1 | Read address bit 0 for identifier |
| id_word | output | DW | Identifier word |

## Verification
The hardest state to reach is the suspended erase. It needs an erase setup, a confirm to an address outside the protected region (or with protection lifted), an accepted request, and then B0h before the engine reports done. Only after all that can the restricted command subset be probed. The random mix weights the command bytes so that 20h, D0h and B0h often fall in that order, and it toggles the protection inputs and the address region while doing so. A reference model in the bench follows every mode. Directed runs force a suspend and resume, a back-pressured request, and refused boot-block jobs.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {SRC_ARRAY = 2'd0, SRC_ID = 2'd1, SRC_STATUS = 2'd2} src_e;
  typedef enum logic [2:0] {ST_IDLE, ST_PSETUP, ST_ESETUP, ST_PBUSY, ST_EBUSY, ST_SUSP} st_e;
  typedef enum logic [3:0] {K_RDARR, K_IDENT, K_RDSTAT, K_CLEAR, K_ESETUP,
                            K_CONFIRM, K_PSETUP, K_SUSP, K_BAD} kind_e;
  localparam logic [7:0] OP_RDARR   = 8'hFF;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_RDSTAT  = 8'h70;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_ESETUP  = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_PSET_A  = 8'h40;
  localparam logic [7:0] OP_PSET_B  = 8'h10;
  localparam logic [7:0] OP_SUSP    = 8'hB0;
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
(
  input  logic [7:0] code,
  output kind_e      kind
);
  always_comb begin
    case (code)
      OP_RDARR:              kind = K_RDARR;
      OP_IDENT:              kind = K_IDENT;
      OP_RDSTAT:             kind = K_RDSTAT;
      OP_CLEAR:              kind = K_CLEAR;
      OP_ESETUP:             kind = K_ESETUP;
      OP_CONFIRM:            kind = K_CONFIRM;
      OP_PSET_A, OP_PSET_B:  kind = K_PSETUP;
      OP_SUSP:               kind = K_SUSP;
      default:               kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/fcs_protect.sv
module fcs_protect #(
  parameter int AW        = 20,
  parameter int BOOT_BITS = 14
) (
  input  logic [AW-1:0] addr,
  input  logic          hv_unlock,
  input  logic          wp_high,
  output logic          blocked
);
  localparam int TOPW = AW - BOOT_BITS;
  logic in_boot;
  assign in_boot = &addr[AW-1:BOOT_BITS];
  assign blocked = in_boot && !hv_unlock && !wp_high;
  initial begin
    a_r7_width: assert (TOPW > 0);
  end
endmodule

// File: rtl/fcs_status.sv
module fcs_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic       suspended,
  input  logic       set_seq,
  input  logic       set_prog_err,
  input  logic       set_erase_err,
  input  logic       set_prot,
  input  logic       clear,
  output logic [7:0] status
);
  logic err_e, err_p, err_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_e <= 1'b0;
      err_p <= 1'b0;
      err_x <= 1'b0;
    end else if (clear) begin
      err_e <= 1'b0;
      err_p <= 1'b0;
      err_x <= 1'b0;
    end else begin
      if (set_seq || set_erase_err) err_e <= 1'b1;
      if (set_seq || set_prog_err)  err_p <= 1'b1;
      if (set_prot)                 err_x <= 1'b1;
    end
  end

  assign status = {ready, suspended, err_e, err_p, err_x, 3'b000};

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[3]) || $fell(status[4]) || $fell(status[5]) |-> $past(clear));
  a_r6_seq_flags: assert property (@(posedge clk) disable iff (!rst_n)
    set_seq && !clear |=> status[5] && status[4]);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int          AW        = 20,
  parameter int          DW        = 16,
  parameter int          BOOT_BITS = 14,
  parameter logic [15:0] MFR_ID    = 16'h0089,
  parameter logic [15:0] DEV_ID    = 16'h889C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          hv_unlock,
  input  logic          wp_high,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_erase,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          eng_suspend,
  output logic          eng_resume,
  input  logic          eng_done,
  input  logic          eng_fail,
  output logic [1:0]    rd_src,
  output logic [7:0]    status,
  input  logic          rd_a0,
  output logic [DW-1:0] id_word
);
  localparam int IDW = (DW < 16) ? DW : 16;

  st_e   st, st_n;
  src_e  src, src_n;
  kind_e kind;
  logic  fire, blocked;
  logic  go_prog, go_erase, sus_p, res_p;
  logic  set_seq, set_prot, clr, err_p, err_e;

  assign wr_ready = !req_valid;
  assign fire     = wr_valid && wr_ready;

  fcs_decode dec_i (.code(wr_data[7:0]), .kind(kind));

  fcs_protect #(.AW(AW), .BOOT_BITS(BOOT_BITS)) prot_i (
    .addr(wr_addr), .hv_unlock(hv_unlock), .wp_high(wp_high), .blocked(blocked));

  always_comb begin
    st_n = st; src_n = src;
    go_prog = 1'b0; go_erase = 1'b0; sus_p = 1'b0; res_p = 1'b0;
    set_seq = 1'b0; set_prot = 1'b0; clr = 1'b0; err_p = 1'b0; err_e = 1'b0;
    if (fire) begin
      case (st)
        ST_IDLE: begin
          case (kind)
            K_RDARR:  src_n = SRC_ARRAY;
            K_IDENT:  src_n = SRC_ID;
            K_RDSTAT: src_n = SRC_STATUS;
            K_CLEAR:  clr = 1'b1;
            K_ESETUP: st_n = ST_ESETUP;
            K_PSETUP: st_n = ST_PSETUP;
            K_SUSP:   ;
            default: begin
              set_seq = 1'b1;
              src_n   = SRC_ARRAY;
            end
          endcase
        end
        ST_PSETUP: begin
          src_n = SRC_STATUS;
          if (blocked) begin
            set_prot = 1'b1;
            st_n     = ST_IDLE;
          end else begin
            go_prog = 1'b1;
            st_n    = ST_PBUSY;
          end
        end
        ST_ESETUP: begin
          if (kind == K_CONFIRM) begin
            src_n = SRC_STATUS;
            if (blocked) begin
              set_prot = 1'b1;
              st_n     = ST_IDLE;
            end else begin
              go_erase = 1'b1;
              st_n     = ST_EBUSY;
            end
          end else begin
            set_seq = 1'b1;
            src_n   = SRC_ARRAY;
            st_n    = ST_IDLE;
          end
        end
        ST_PBUSY, ST_EBUSY: begin
          case (kind)
            K_RDARR:  src_n = SRC_ARRAY;
            K_IDENT:  src_n = SRC_ID;
            K_RDSTAT: src_n = SRC_STATUS;
            K_SUSP: begin
              if (st == ST_EBUSY) begin
                sus_p = 1'b1;
                st_n  = ST_SUSP;
              end
            end
            default: ;
          endcase
        end
        ST_SUSP: begin
          case (kind)
            K_RDARR:  src_n = SRC_ARRAY;
            K_RDSTAT: src_n = SRC_STATUS;
            K_CONFIRM: begin
              res_p = 1'b1;
              src_n = SRC_STATUS;
              st_n  = ST_EBUSY;
            end
            default: ;
          endcase
        end
        default: st_n = ST_IDLE;
      endcase
    end
    if (eng_done && (st == ST_PBUSY || st == ST_EBUSY)) begin
      st_n  = ST_IDLE;
      sus_p = 1'b0;
      err_p = eng_fail && (st == ST_PBUSY);
      err_e = eng_fail && (st == ST_EBUSY);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      src         <= SRC_ARRAY;
      req_valid   <= 1'b0;
      req_erase   <= 1'b0;
      req_addr    <= '0;
      req_data    <= '0;
      eng_suspend <= 1'b0;
      eng_resume  <= 1'b0;
    end else begin
      st          <= st_n;
      src         <= src_n;
      eng_suspend <= sus_p;
      eng_resume  <= res_p;
      if (go_prog || go_erase) begin
        req_valid <= 1'b1;
        req_erase <= go_erase;
        req_addr  <= wr_addr;
        req_data  <= go_prog ? wr_data : '0;
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  fcs_status stat_i (
    .clk(clk), .rst_n(rst_n),
    .ready(!(st == ST_PBUSY || st == ST_EBUSY)),
    .suspended(st == ST_SUSP),
    .set_seq(set_seq), .set_prog_err(err_p), .set_erase_err(err_e),
    .set_prot(set_prot), .clear(clr), .status(status));

  assign rd_src = src;

  always_comb begin
    id_word = '0;
    id_word[IDW-1:0] = rd_a0 ? DEV_ID[IDW-1:0] : MFR_ID[IDW-1:0];
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_erase));
  a_r4_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !status[7]);
  a_r8_susp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    eng_suspend |-> status[6] && status[7]);
  a_r9_resume_flag: assert property (@(posedge clk) disable iff (!rst_n)
    eng_resume |-> !status[6] && !status[7]);
  a_r8_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_suspend, eng_resume, req_valid && req_ready}));
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam logic [15:0] MFR = 16'h0089;
  localparam logic [15:0] DEV = 16'h889C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic hv_unlock = 1'b0, wp_high = 1'b0;
  logic req_valid, req_ready = 1'b1, req_erase;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic eng_suspend, eng_resume;
  logic eng_done = 1'b0, eng_fail = 1'b0;
  logic [1:0] rd_src;
  logic [7:0] status;
  logic rd_a0 = 1'b0;
  logic [DW-1:0] id_word;

  always #5 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .DW(DW), .BOOT_BITS(14), .MFR_ID(MFR), .DEV_ID(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .hv_unlock(hv_unlock), .wp_high(wp_high),
    .req_valid(req_valid), .req_ready(req_ready), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .eng_suspend(eng_suspend),
    .eng_resume(eng_resume), .eng_done(eng_done), .eng_fail(eng_fail),
    .rd_src(rd_src), .status(status), .rd_a0(rd_a0), .id_word(id_word));

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  int m_st = 0;           // 0 idle 1 psetup 2 esetup 3 pbusy 4 ebusy 5 susp
  int m_src = 0;
  bit m_s5 = 0, m_s4 = 0, m_s3 = 0;
  bit x_req, x_erase, x_sus, x_res;
  logic [AW-1:0] x_addr;
  logic [DW-1:0] x_data;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {!(m_st == 3 || m_st == 4), m_st == 5, m_s5, m_s4, m_s3, 3'b000};
  endfunction

  function automatic bit in_boot(logic [AW-1:0] a);
    return (a[AW-1:14] == '1) && !hv_unlock && !wp_high;
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [DW-1:0] d);
    logic [7:0] c = d[7:0];
    x_req = 0; x_sus = 0; x_res = 0;
    case (m_st)
      0: begin
        if (c == 8'hFF) m_src = 0;
        else if (c == 8'h90) m_src = 1;
        else if (c == 8'h70) m_src = 2;
        else if (c == 8'h50) begin m_s5 = 0; m_s4 = 0; m_s3 = 0; end
        else if (c == 8'h20) m_st = 2;
        else if (c == 8'h40 || c == 8'h10) m_st = 1;
        else if (c == 8'hB0) ;
        else begin m_s5 = 1; m_s4 = 1; m_src = 0; end
      end
      1: begin
        m_src = 2;
        if (in_boot(a)) begin m_s3 = 1; m_st = 0; end
        else begin x_req = 1; x_erase = 0; x_addr = a; x_data = d; m_st = 3; end
      end
      2: begin
        if (c == 8'hD0) begin
          m_src = 2;
          if (in_boot(a)) begin m_s3 = 1; m_st = 0; end
          else begin x_req = 1; x_erase = 1; x_addr = a; x_data = '0; m_st = 4; end
        end else begin m_s5 = 1; m_s4 = 1; m_src = 0; m_st = 0; end
      end
      3, 4: begin
        if (c == 8'hFF) m_src = 0;
        else if (c == 8'h90) m_src = 1;
        else if (c == 8'h70) m_src = 2;
        else if (c == 8'hB0 && m_st == 4) begin x_sus = 1; m_st = 5; end
      end
      default: begin
        if (c == 8'hFF) m_src = 0;
        else if (c == 8'h70) m_src = 2;
        else if (c == 8'hD0) begin x_res = 1; m_src = 2; m_st = 4; end
      end
    endcase
  endtask

  task automatic check_all(string tag);
    chk({tag, " src R2"}, 32'(rd_src), 32'(m_src));
    chk({tag, " status R10"}, 32'(status), 32'(exp_status()));
    chk({tag, " req R4/R5"}, 32'(req_valid), 32'(x_req));
    chk({tag, " suspend R8"}, 32'(eng_suspend), 32'(x_sus));
    chk({tag, " resume R9"}, 32'(eng_resume), 32'(x_res));
    if (x_req && req_valid) begin
      chk({tag, " req kind R5"}, 32'(req_erase), 32'(x_erase));
      chk({tag, " req addr R5"}, 32'(req_addr), 32'(x_addr));
      if (!x_erase) chk({tag, " req data R5"}, 32'(req_data), 32'(x_data));
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    while (!wr_ready) @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic engine_done(bit f, string tag);
    @(negedge clk);
    eng_done = 1'b1; eng_fail = f;
    @(posedge clk);
    x_req = 0; x_sus = 0; x_res = 0;
    if (m_st == 3 || m_st == 4) begin
      if (f && m_st == 3) m_s4 = 1;
      if (f && m_st == 4) m_s5 = 1;
      m_st = 0;
    end
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0;
    check_all(tag);
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    logic [AW-1:0] a = AW'($urandom);
    if ($urandom % 2) a[AW-1:14] = '1;
    return a;
  endfunction

  function automatic logic [7:0] rnd_cmd();
    case ($urandom % 11)
      0: return 8'hFF; 1: return 8'h90; 2: return 8'h70; 3: return 8'h50;
      4, 9: return 8'h20; 5: return 8'h40; 6: return 8'h10;
      7, 10: return 8'hD0; 8: return 8'hB0;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1F2E3D4C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("reset src R1", 32'(rd_src), 0);
    chk("reset status R1", 32'(status), 32'h80);
    chk("reset req R1", 32'(req_valid), 0);
    chk("reset wr_ready R11", 32'(wr_ready), 1);
    // R2 identifier
    bus_write(20'h00010, 16'h0090, "ident");
    rd_a0 = 1'b0; #1 chk("id mfr R2", 32'(id_word), 32'(MFR));
    rd_a0 = 1'b1; #1 chk("id dev R2", 32'(id_word), 32'(DEV));
    bus_write(20'h00000, 16'h0070, "rdstat R2");
    // R6 invalid codes
    bus_write(20'h00000, 16'h0000, "code00 R6");
    bus_write(20'h00000, 16'h0070, "rdstat");
    bus_write(20'h00000, 16'h0050, "clear R3");
    bus_write(20'h00000, 16'hAB5A, "unlisted R6");
    bus_write(20'h00000, 16'h00D0, "lone confirm R6");
    bus_write(20'h00000, 16'h0050, "clear R3");
    bus_write(20'h00000, 16'h0020, "esetup");
    bus_write(20'h00000, 16'h00FF, "broken erase R6");
    // R5 program, word data
    bus_write(20'h00000, 16'h0040, "psetup R5");
    bus_write(20'h01234, 16'hBEEF, "prog R5");
    bus_write(20'h00000, 16'h00B0, "B0 during prog R8");
    engine_done(1'b1, "prog fail R10");
    bus_write(20'h00000, 16'h0050, "clear R3");
    // R7 boot protection
    bus_write(20'h00000, 16'h0010, "psetup alt R5");
    bus_write(20'hFC000, 16'h1234, "boot prog blocked R7");
    wp_high = 1'b1;
    bus_write(20'h00000, 16'h0020, "esetup");
    bus_write(20'hFFFFF, 16'h00D0, "boot erase wp R7");
    wp_high = 1'b0;
    // R8/R9 suspend and resume
    bus_write(20'h00000, 16'h0090, "busy ident R10");
    bus_write(20'h00000, 16'h00B0, "suspend R8");
    bus_write(20'h00000, 16'h0090, "susp ident ignored R9");
    bus_write(20'h00000, 16'h0040, "susp psetup ignored R9");
    bus_write(20'h00000, 16'h00FF, "susp rdarr R9");
    bus_write(20'h00000, 16'h00D0, "resume R9");
    engine_done(1'b0, "erase ok R10");
    engine_done(1'b1, "stray done R10");
    // R11 back-pressure
    req_ready = 1'b0;
    bus_write(20'h00000, 16'h0040, "psetup");
    bus_write(20'h00200, 16'h5555, "prog bp R11");
    repeat (3) begin
      @(negedge clk);
      chk("bp hold valid R11", 32'(req_valid), 1);
      chk("bp hold addr R11", 32'(req_addr), 32'h00200);
      chk("bp wr_ready R11", 32'(wr_ready), 0);
    end
    req_ready = 1'b1;
    @(negedge clk);
    x_req = 0;
    chk("bp release R11", 32'(req_valid), 0);
    engine_done(1'b0, "prog ok R10");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom % 12);
      if (r < 8) bus_write(rnd_addr(), {8'($urandom), rnd_cmd()}, "rand cmd");
      else if (r < 9) bus_write(rnd_addr(), 16'($urandom), "rand data");
      else if (r < 11) engine_done(bit'($urandom % 2), "rand done");
      else begin
        hv_unlock = ($urandom % 4) == 0;
        wp_high   = ($urandom % 4) == 0;
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule